// File: doc/BRIEF.md
# ROM Image Copy Engine with Folding Checksum

This block moves a boot image out of a set of byte-wide ROM chips into word-wide RAM after a single start request. It walks the chips in turn and reads two successive bytes per word. It writes each assembled 16-bit word to the next RAM location. While it copies, it folds every word into a 16-bit running sum: the word is added, any carry out is added back in at bit 0, and the sum is then rotated left by one place.

When the image ends, the block raises a one-cycle completion pulse. At the same time it gives a verdict: the image is good only if the folded sum came to all ones. A bad verdict raises a separate fault flag. Both verdict outputs hold until the next copy is started.

The first chip is read from one page in, at the same page offset the RAM copy starts at. A page is `PAGE_WORDS` words, or twice that many bytes. Every later chip is read from its first byte. Each chip is read up to the last byte of its `2**CHIP_AW`-byte window. Every ROM read holds its address for a parameterised number of wait cycles before the byte is taken.

Top module: `rom_copy_engine`

## Requirements
- R1: While reset is asserted, and after it is released until a start is taken, `done`, `checksum_ok`, `bad_sum`, `rom_rd` and `ram_we` are all low.
- R2: A `start` taken in the idle state begins a copy. RAM writes begin at word address `START_PAGE*PAGE_WORDS` and rise by exactly one per word, with one `ram_we` cycle per word.
- R3: Each RAM word is two consecutive ROM bytes. The byte read first goes in bits 15:8 and the byte read second goes in bits 7:0.
- R4: During every read, `rom_addr` carries ones in its two most significant bits and the byte offset in bits `CHIP_AW-1:0`. All bits between those fields are zero.
- R5: Every byte read keeps `rom_rd` high and `rom_cs`/`rom_addr` unchanged for exactly `WAIT_CYCLES+1` cycles. The byte is taken at the end of the last of those cycles.
- R6: Chip 0 is read from byte offset `2*START_PAGE*PAGE_WORDS`. Chips 1 to `NUM_CHIPS-1` are read from offset 0. Each chip is read through offset `2**CHIP_AW-1`, and `rom_cs` then advances by one. The copy ends after the last byte of chip `NUM_CHIPS-1`.
- R7: The running sum is zero when a copy is started. For each word it becomes rotl1(low16(sum+word) + carry), where carry is bit 16 of sum+word.
- R8: `done` is high for exactly one cycle, the cycle right after the final `ram_we` cycle.
- R9: With `done`, `checksum_ok` is high when the final sum is 16'hFFFF and `bad_sum` is high otherwise. Exactly one of them is set. Both hold their values until the next accepted `start`, which clears them.
- R10: A `start` seen while a copy is running, or in the `done` cycle, is ignored. The copy's addresses, data and verdict are unaffected, and no new copy begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a copy (taken when idle) |
| rom_cs | output | CHIP_W | Index of the ROM chip being read |
| rom_rd | output | 1 | ROM read in progress |
| rom_addr | output | ROM_ADDR_W | ROM byte address, top two bits forced high |
| rom_data | input | 8 | Byte returned by the selected ROM |
| ram_we | output | 1 | RAM word write strobe |
| ram_addr | output | RAM_AW | RAM word address |
| ram_wdata | output | 16 | Assembled word to write |
| done | output | 1 | One-cycle copy-complete pulse |
| checksum_ok | output | 1 | Final folded sum was all ones |
| bad_sum | output | 1 | Fatal fault: final folded sum was not all ones |

## Verification
The completion pulse and a fresh start request can fall in the same cycle. The bench drives `start` high during exactly the `done` cycle of a corrupted-image run. It then requires that `done` falls and that `rom_rd` stays low for the following cycles, so that no second copy begins. It also requires the fault verdict to hold unchanged. A second overlap is a start request arriving mid-copy, while a byte is being fetched. The scoreboard confirms that the word addresses and data carry on in sequence as if the request never came.

// File: rtl/rce_pkg.sv
package rce_pkg;

  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RD_HI  = 3'd1,
    ST_RD_LO  = 3'd2,
    ST_WRITE  = 3'd3,
    ST_FINISH = 3'd4
  } copy_state_e;

  // One step of the folding sum: add, wrap carry to bit 0, rotate left by one.
  function automatic logic [WORD_W-1:0] csum_fold(input logic [WORD_W-1:0] acc,
                                                   input logic [WORD_W-1:0] w);
    logic [WORD_W:0]   raw;
    logic [WORD_W-1:0] wrapped;
    raw     = {1'b0, acc} + {1'b0, w};
    wrapped = raw[WORD_W-1:0] + {{(WORD_W-1){1'b0}}, raw[WORD_W]};
    return {wrapped[WORD_W-2:0], wrapped[WORD_W-1]};
  endfunction

endpackage

// File: rtl/rce_wait_timer.sv
module rce_wait_timer #(
  parameter int WAIT_CYCLES = 2,
  localparam int CW = (WAIT_CYCLES > 0) ? $clog2(WAIT_CYCLES + 1) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic take
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign take = active && (cnt_q == CW'(WAIT_CYCLES));

  always_comb begin
    cnt_en = active || (cnt_q != '0);
    if (!active || take) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  generate
    if (WAIT_CYCLES > 0) begin : g_wait_chk
      AST_TAKE_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> $past(active)); // R5
    end
  endgenerate

endmodule

// File: rtl/rce_rom_seq.sv
module rce_rom_seq #(
  parameter int NUM_CHIPS = 3,
  parameter int CHIP_AW   = 13,
  parameter int CHIP_W    = 2,
  parameter int FIRST_OFF = 512
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  output logic [CHIP_W-1:0]  chip,
  output logic [CHIP_AW-1:0] offset,
  output logic               last_byte
);

  localparam logic [CHIP_AW-1:0] OFF_MAX   = '1;
  localparam logic [CHIP_AW-1:0] OFF_FIRST = CHIP_AW'(FIRST_OFF);
  localparam logic [CHIP_W-1:0]  CHIP_LAST = CHIP_W'(NUM_CHIPS - 1);

  logic [CHIP_W-1:0]  chip_q, chip_d;
  logic [CHIP_AW-1:0] off_q, off_d;
  logic               seq_en;
  logic               chip_end;

  assign chip_end  = (off_q == OFF_MAX);
  assign last_byte = chip_end && (chip_q == CHIP_LAST);
  assign chip      = chip_q;
  assign offset    = off_q;

  always_comb begin
    seq_en = load || step;
    chip_d = chip_q;
    off_d  = off_q;
    if (load) begin
      chip_d = '0;
      off_d  = OFF_FIRST;
    end else if (step) begin
      if (chip_end) begin
        off_d = '0;
        if (chip_q != CHIP_LAST) chip_d = chip_q + 1'b1;
      end else begin
        off_d = off_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chip_q <= '0;
      off_q  <= '0;
    end else if (seq_en) begin
      chip_q <= chip_d;
      off_q  <= off_d;
    end
  end

  AST_CHIP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    chip_q <= CHIP_LAST); // R6

endmodule

// File: rtl/rce_checksum.sv
module rce_checksum
  import rce_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              add,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] sum,
  output logic [WORD_W-1:0] sum_next
);

  logic [WORD_W-1:0] sum_q, sum_d;
  logic              sum_en;

  assign sum_next = csum_fold(sum_q, word);
  assign sum      = sum_q;

  always_comb begin
    sum_en = clear || add;
    if (clear)    sum_d = '0;
    else if (add) sum_d = sum_next;
    else          sum_d = sum_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sum_q <= '0;
    else if (sum_en) sum_q <= sum_d;
  end

  AST_ONES_FIXED_POINT: assert property (@(posedge clk) disable iff (!rst_n)
    (add && !clear && sum_q == '1 && word == '0) |=> (sum_q == '1)); // R7
  AST_ZERO_FIXED_POINT: assert property (@(posedge clk) disable iff (!rst_n)
    (add && !clear && sum_q == '0 && word == '0) |=> (sum_q == '0)); // R7

endmodule

// File: rtl/rom_copy_engine.sv
module rom_copy_engine
  import rce_pkg::*;
#(
  parameter int NUM_CHIPS   = 3,
  parameter int CHIP_AW     = 13,
  parameter int ROM_ADDR_W  = 16,
  parameter int PAGE_WORDS  = 256,
  parameter int START_PAGE  = 1,
  parameter int RAM_AW      = 20,
  parameter int WAIT_CYCLES = 2,
  localparam int CHIP_W     = (NUM_CHIPS > 1) ? $clog2(NUM_CHIPS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  output logic [CHIP_W-1:0]     rom_cs,
  output logic                  rom_rd,
  output logic [ROM_ADDR_W-1:0] rom_addr,
  input  logic [BYTE_W-1:0]     rom_data,
  output logic                  ram_we,
  output logic [RAM_AW-1:0]     ram_addr,
  output logic [WORD_W-1:0]     ram_wdata,
  output logic                  done,
  output logic                  checksum_ok,
  output logic                  bad_sum
);

  localparam int FIRST_OFF = 2 * START_PAGE * PAGE_WORDS;
  localparam int RAM_BASE  = START_PAGE * PAGE_WORDS;
  localparam int PAD_W     = ROM_ADDR_W - 2 - CHIP_AW;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  copy_state_e state_q, state_d;
  logic [BYTE_W-1:0] hi_q, hi_d, lo_q, lo_d;
  logic [RAM_AW-1:0] waddr_q, waddr_d;
  logic              fin_q, fin_d;
  logic              ok_q, ok_d, bad_q, bad_d;
  logic              accept;
  logic              rd_active;
  logic              take;
  logic              last_byte;
  logic              hi_en, lo_en, waddr_en, fin_en, verdict_en;
  logic [CHIP_W-1:0]  seq_chip;
  logic [CHIP_AW-1:0] seq_off;
  logic [WORD_W-1:0]  word;
  logic [WORD_W-1:0]  sum_cur;
  logic [WORD_W-1:0]  sum_next;

  assign accept    = (state_q == ST_IDLE) && start;
  assign rd_active = (state_q == ST_RD_HI) || (state_q == ST_RD_LO);
  assign word      = {hi_q, lo_q};

  rce_wait_timer #(
    .WAIT_CYCLES (WAIT_CYCLES)
  ) u_wait (
    .clk    (clk),
    .rst_n  (rst_ns),
    .active (rd_active),
    .take   (take)
  );

  rce_rom_seq #(
    .NUM_CHIPS (NUM_CHIPS),
    .CHIP_AW   (CHIP_AW),
    .CHIP_W    (CHIP_W),
    .FIRST_OFF (FIRST_OFF)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_ns),
    .load      (accept),
    .step      (take),
    .chip      (seq_chip),
    .offset    (seq_off),
    .last_byte (last_byte)
  );

  rce_checksum u_sum (
    .clk      (clk),
    .rst_n    (rst_ns),
    .clear    (accept),
    .add      (state_q == ST_WRITE),
    .word     (word),
    .sum      (sum_cur),
    .sum_next (sum_next)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (accept) state_d = ST_RD_HI;
      ST_RD_HI:  if (take)   state_d = ST_RD_LO;
      ST_RD_LO:  if (take)   state_d = ST_WRITE;
      ST_WRITE:  state_d = fin_q ? ST_FINISH : ST_RD_HI;
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  // datapath next values with explicit enables
  always_comb begin
    hi_en = (state_q == ST_RD_HI) && take;
    hi_d  = rom_data;
    lo_en = (state_q == ST_RD_LO) && take;
    lo_d  = rom_data;

    waddr_en = accept || (state_q == ST_WRITE);
    waddr_d  = accept ? RAM_AW'(RAM_BASE) : waddr_q + 1'b1;

    fin_en = accept || lo_en;
    fin_d  = accept ? 1'b0 : last_byte;

    verdict_en = accept || ((state_q == ST_WRITE) && fin_q);
    ok_d       = !accept && (sum_next == '1);
    bad_d      = !accept && (sum_next != '1);
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (hi_en) hi_q <= hi_d;
      if (lo_en) lo_q <= lo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      waddr_q <= '0;
      fin_q   <= 1'b0;
      ok_q    <= 1'b0;
      bad_q   <= 1'b0;
    end else begin
      if (waddr_en)   waddr_q <= waddr_d;
      if (fin_en)     fin_q   <= fin_d;
      if (verdict_en) begin
        ok_q  <= ok_d;
        bad_q <= bad_d;
      end
    end
  end

  // ROM address: two forced-high bits, zero padding, byte offset
  generate
    if (PAD_W > 0) begin : g_pad
      assign rom_addr = {2'b11, {PAD_W{1'b0}}, seq_off};
    end else begin : g_nopad
      assign rom_addr = {2'b11, seq_off};
    end
  endgenerate

  assign rom_cs      = seq_chip;
  assign rom_rd      = rd_active;
  assign ram_we      = (state_q == ST_WRITE);
  assign ram_addr    = waddr_q;
  assign ram_wdata   = word;
  assign done        = (state_q == ST_FINISH);
  assign checksum_ok = ok_q;
  assign bad_sum     = bad_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_ns)
    done |=> !done); // R8
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_ns)
    done |-> $past(ram_we)); // R8
  AST_VERDICT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_ns)
    done |-> (checksum_ok ^ bad_sum)); // R9
  AST_VERDICT_HELD: assert property (@(posedge clk) disable iff (!rst_ns)
    (!accept && !((state_q == ST_WRITE) && fin_q)) |=> ($stable(checksum_ok) && $stable(bad_sum))); // R9
  AST_RAM_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_ns)
    (ram_we && !fin_q) |=> (ram_addr == $past(ram_addr) + 1'b1)); // R2
  AST_WORD_EVEN_OFFSET: assert property (@(posedge clk) disable iff (!rst_ns)
    (ram_we && !fin_q) |-> (rom_addr[0] == 1'b0)); // R6
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_ns)
    (start && (state_q == ST_RD_HI) && !take) |=> ($stable(ram_addr) && $stable(rom_addr) && $stable(rom_cs))); // R10
  AST_SUM_CLEARED: assert property (@(posedge clk) disable iff (!rst_ns)
    accept |=> (sum_cur == '0)); // R7

endmodule

// File: tb/tb_rom_copy_engine.sv
module tb_rom_copy_engine;

  localparam int TB_CHIPS = 3;
  localparam int TB_AW    = 6;
  localparam int TB_PW    = 4;
  localparam int TB_SP    = 1;
  localparam int TB_WAIT  = 2;
  localparam int TB_RAW   = 10;
  localparam int TB_ROMW  = 16;
  localparam int CHIP_BYTES = 1 << TB_AW;
  localparam int RAM_BASE   = TB_SP * TB_PW;
  localparam int FIRST_OFF  = 2 * TB_SP * TB_PW;

  logic                clk;
  logic                rst_n;
  logic                start;
  logic [1:0]          rom_cs;
  logic                rom_rd;
  logic [TB_ROMW-1:0]  rom_addr;
  logic [7:0]          rom_data;
  logic                ram_we;
  logic [TB_RAW-1:0]   ram_addr;
  logic [15:0]         ram_wdata;
  logic                done;
  logic                checksum_ok;
  logic                bad_sum;

  rom_copy_engine #(
    .NUM_CHIPS   (TB_CHIPS),
    .CHIP_AW     (TB_AW),
    .ROM_ADDR_W  (TB_ROMW),
    .PAGE_WORDS  (TB_PW),
    .START_PAGE  (TB_SP),
    .RAM_AW      (TB_RAW),
    .WAIT_CYCLES (TB_WAIT)
  ) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .rom_cs      (rom_cs),
    .rom_rd      (rom_rd),
    .rom_addr    (rom_addr),
    .rom_data    (rom_data),
    .ram_we      (ram_we),
    .ram_addr    (ram_addr),
    .ram_wdata   (ram_wdata),
    .done        (done),
    .checksum_ok (checksum_ok),
    .bad_sum     (bad_sum)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input bit cond, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  function automatic logic [15:0] ref_fold(input logic [15:0] a, input logic [15:0] w);
    logic [16:0] s;
    logic [15:0] f;
    s = {1'b0, a} + {1'b0, w};
    f = s[15:0] + {15'd0, s[16]};
    return {f[14:0], f[15]};
  endfunction

  logic [15:0] patch_word;

  function automatic logic [7:0] base_byte(input int c, input int o);
    int v;
    v = c * 71 + o * 29 + (o >> 3) + 5;
    return 8'(v) ^ 8'h3C;
  endfunction

  function automatic logic [7:0] image_byte(input int c, input int o);
    if (c == TB_CHIPS - 1 && o == CHIP_BYTES - 2) return patch_word[15:8];
    if (c == TB_CHIPS - 1 && o == CHIP_BYTES - 1) return patch_word[7:0];
    return base_byte(c, o);
  endfunction

  // ROM model: returns the true byte only once the read has been held WAIT cycles
  int hold_cnt;
  logic [TB_ROMW+1:0] hold_key;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_cnt <= 0;
      hold_key <= '0;
    end else begin
      if (rom_rd && ({rom_cs, rom_addr} == hold_key)) hold_cnt <= hold_cnt + 1;
      else hold_cnt <= rom_rd ? 1 : 0;
      hold_key <= {rom_cs, rom_addr};
    end
  end

  always_comb begin
    if (hold_cnt >= TB_WAIT) rom_data = image_byte(int'(rom_cs), int'(rom_addr[TB_AW-1:0]));
    else                     rom_data = ~image_byte(int'(rom_cs), int'(rom_addr[TB_AW-1:0]));
  end

  // ---------------- scoreboard ----------------
  typedef struct packed {
    logic [TB_RAW-1:0] a;
    logic [15:0]       d;
  } item_t;

  item_t       exp_q[$];
  logic [15:0] exp_final;
  bit          exp_ok;

  // driver: builds the expected RAM writes and verdict for one copy
  task automatic push_expected(input bit corrupt);
    logic [15:0] s;
    logic [15:0] w;
    int idx;
    item_t it;
    s = 16'h0000;
    idx = 0;
    exp_q.delete();
    for (int c = 0; c < TB_CHIPS; c++) begin
      for (int o = (c == 0 ? FIRST_OFF : 0); o < CHIP_BYTES; o += 2) begin
        if (c == TB_CHIPS - 1 && o == CHIP_BYTES - 2) begin
          w = corrupt ? (~s ^ 16'h0001) : ~s;
          patch_word = w;
        end else begin
          w = {base_byte(c, o), base_byte(c, o + 1)};
        end
        it.a = TB_RAW'(RAM_BASE + idx);
        it.d = w;
        exp_q.push_back(it);
        s = ref_fold(s, w);
        idx++;
      end
    end
    exp_final = s;
    exp_ok    = (s == 16'hFFFF);
  endtask

  // monitor: compares writes and watches read timing at the falling edge
  time              last_we_time = 0;
  bit               prev_rd = 1'b0;
  logic [TB_ROMW+1:0] prev_key = '0;
  int               run_len = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ram_we) begin
        last_we_time = $time;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected write", 32'(ram_addr), 32'hFFFF);
        end else begin
          item_t it;
          it = exp_q.pop_front();
          chk(ram_addr == it.a, "R2 ram address", 32'(ram_addr), 32'(it.a));
          chk(ram_wdata == it.d, "R3 R6 word value", 32'(ram_wdata), 32'(it.d));
        end
      end
      if (rom_rd && prev_rd && ({rom_cs, rom_addr} == prev_key)) begin
        run_len++;
      end else begin
        if (prev_rd) chk(run_len == TB_WAIT + 1, "R5 read hold length", 32'(run_len), 32'(TB_WAIT + 1));
        if (rom_rd) begin
          run_len = 1;
          chk(rom_addr[TB_ROMW-1:TB_ROMW-2] == 2'b11, "R4 top bits", 32'(rom_addr), 32'hC000);
          chk(rom_addr[TB_ROMW-3:TB_AW] == '0, "R4 pad bits", 32'(rom_addr), 32'hC000);
        end else begin
          run_len = 0;
        end
      end
      prev_rd  = rom_rd;
      prev_key = {rom_cs, rom_addr};
    end
  end

  // ---------------- runs ----------------
  task automatic run_copy(input bit corrupt, input bit poke_busy, input bit poke_done);
    push_expected(corrupt);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(checksum_ok == 1'b0 && bad_sum == 1'b0, "R9 verdict cleared by start",
        {30'd0, checksum_ok, bad_sum}, 32'd0);
    chk(rom_rd == 1'b1 && rom_cs == 2'd0 && rom_addr[TB_AW-1:0] == TB_AW'(FIRST_OFF),
        "R6 first read position", {rom_rd, 7'd0, 6'(rom_cs), 18'(rom_addr)}, 32'(FIRST_OFF));
    if (poke_busy) begin
      repeat (41) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all words written", 32'(exp_q.size()), 32'd0);
    chk(($time - last_we_time) == 8, "R8 done follows last write", 32'($time - last_we_time), 32'd8);
    chk(checksum_ok == exp_ok, "R7 R9 checksum_ok", 32'(checksum_ok), 32'(exp_ok));
    chk(bad_sum == !exp_ok, "R9 bad_sum", 32'(bad_sum), 32'(!exp_ok));
    if (poke_done) start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R8 done one cycle", 32'(done), 32'd0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(rom_rd == 1'b0 && ram_we == 1'b0, "R10 no restart", {30'd0, rom_rd, ram_we}, 32'd0);
      chk(checksum_ok == exp_ok && bad_sum == !exp_ok, "R9 verdict held",
          {30'd0, checksum_ok, bad_sum}, {30'd0, exp_ok, !exp_ok});
    end
  endtask

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    patch_word = 16'h0000;
    repeat (3) @(negedge clk);
    chk({done, checksum_ok, bad_sum, rom_rd, ram_we} == 5'd0, "R1 outputs in reset",
        32'({done, checksum_ok, bad_sum, rom_rd, ram_we}), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({done, checksum_ok, bad_sum, rom_rd, ram_we} == 5'd0, "R1 outputs after reset",
        32'({done, checksum_ok, bad_sum, rom_rd, ram_we}), 32'd0);

    run_copy(1'b0, 1'b0, 1'b0);   // good image
    run_copy(1'b1, 1'b1, 1'b1);   // bad image, start pokes while busy and on done
    run_copy(1'b0, 1'b0, 1'b0);   // good again, verdict flips back

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule